// File: doc/BRIEF.md
# Priority Interrupt Collector with Level Acknowledge

The block gathers level-sensitive interrupt lines from a parameterised number of peripherals and presents a single interrupt request to a processor. Alongside the request it provides the vector number of the winning source. Each source owns a small control word that holds an enable bit and a priority field. The word can be written whole, or one bit group at a time through a set alias and a clear alias.

The processor reads the presented vector and its priority level from a status word. It then writes anything to the vector register, which withdraws the request so that interrupts can be re-enabled while the handler runs. The handler finishes by writing a one-hot word to the level-acknowledge register, and that write reopens the level.

Nesting is tracked per level. A level stays blocked from the moment a request at that level is presented until its acknowledge arrives. A new request is presented only if its level is strictly above every level still in service. If the presented source drops its line or is disabled before the handler reads the status, the vector reads as the reserved "no source" code 0x7f. Its level remains in service and must still be acknowledged.

Top module: `prio_irq_collector`

## Requirements
- R1: After synchronous reset the interrupt output is low, the status word reads 0x0000007f, every control word reads zero, and the in-service mask reads zero.
- R2: The control word of source n sits at byte address 0x100 + 16*n. Bit 4 is the enable and bits [1:0] are the priority level (0 lowest, 3 highest). A write replaces both fields, other bits read as zero, and a read returns the stored word.
- R3: Writing to 0x104 + 16*n sets, and writing to 0x108 + 16*n clears, exactly those control-word bits that are one in the written data. All other bits keep their value.
- R4: Among sources whose line is high and whose enable is set, the highest priority level wins, and ties go to the lowest source number. Disabled sources never win.
- R5: The interrupt output rises on the first clock edge at which an eligible winner exists and no request is presented. The status word at 0x000 then holds the latched vector in bits [6:0], its level in bits [9:8] and the request flag in bit 31.
- R6: A request is presented only when its level is strictly greater than every level in service. Presenting a request puts its level in service.
- R7: Any write to 0x010 drops the interrupt output at that clock edge, and the status vector returns to 0x7f.
- R8: A write to 0x020 of a one-hot word whose set bit is a level in service removes that level from service. Reading 0x020 returns the in-service mask in bits [3:0].
- R9: A write to 0x020 whose data is not one-hot, or whose bit names a level not in service, leaves the in-service mask unchanged.
- R10: While a request is presented, if the latched source's line falls or its enable clears, the status vector reads 0x7f from the next edge on. The level field and the in-service mask are kept.
- R11: Read data appears one clock after the read strobe. Addresses that are not mapped, including control-word slots beyond the last source, read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | NUM_SRC | Level-sensitive interrupt lines, one per source |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
A change on a source line or an enable write reaches `irq_o` at the next rising edge. Read data lands one edge after the strobe. A vector write or an acknowledge write takes effect at the edge that samples it. So the bench drives every input on a falling edge and samples outputs on a later falling edge, placed after exactly the number of rising edges that the path holds. A re-raise that depends on an acknowledge is checked one edge after the edge at which the acknowledge takes effect. Checks that a value is held or that a write is ignored are made after at least two further edges, so that a late change would also be caught.

// File: rtl/icol_pkg.sv
package icol_pkg;
  localparam int DATA_W  = 32;
  localparam int VEC_W   = 7;
  localparam int EN_BIT  = 4;
  localparam int LVL_POS = 8;
  localparam logic [VEC_W-1:0] NO_SRC = 7'h7f;

  typedef enum logic [1:0] {
    SUB_DIRECT = 2'd0,
    SUB_SET    = 2'd1,
    SUB_CLR    = 2'd2,
    SUB_RSVD   = 2'd3
  } sub_e;
endpackage

// File: rtl/icol_src_bank.sv
module icol_src_bank
  import icol_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int LVL_W   = 2,
  parameter int ADDR_W  = 12
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            wr_i,
  input  logic [ADDR_W-1:0]               addr_i,
  input  logic [DATA_W-1:0]               wdata_i,
  output logic [NUM_SRC-1:0]              en_o,
  output logic [NUM_SRC-1:0][LVL_W-1:0]   prio_o,
  output logic                            rd_hit_o,
  output logic [DATA_W-1:0]               rd_word_o
);
  localparam int SLOT_W = ADDR_W - 4;
  localparam logic [SLOT_W-1:0] BASE_SLOT = SLOT_W'(16);
  localparam logic [SLOT_W-1:0] END_SLOT  = SLOT_W'(16 + NUM_SRC);

  logic [SLOT_W-1:0] slot, rel;
  logic              in_bank;
  sub_e              sub;
  logic              unused_bits;

  assign slot    = addr_i[ADDR_W-1:4];
  assign in_bank = (slot >= BASE_SLOT) && (slot < END_SLOT);
  assign rel     = slot - BASE_SLOT;
  assign sub     = sub_e'(addr_i[3:2]);
  assign unused_bits = ^{wdata_i, addr_i[1:0]};

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    logic             hit;
    logic             en_q;
    logic [LVL_W-1:0] prio_q;

    assign hit = wr_i && in_bank && (rel == SLOT_W'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        en_q   <= 1'b0;
        prio_q <= '0;
      end else if (hit) begin
        case (sub)
          SUB_DIRECT: begin
            en_q   <= wdata_i[EN_BIT];
            prio_q <= wdata_i[LVL_W-1:0];
          end
          SUB_SET: begin
            en_q   <= en_q | wdata_i[EN_BIT];
            prio_q <= prio_q | wdata_i[LVL_W-1:0];
          end
          SUB_CLR: begin
            en_q   <= en_q & ~wdata_i[EN_BIT];
            prio_q <= prio_q & ~wdata_i[LVL_W-1:0];
          end
          default: ;
        endcase
      end
    end

    assign en_o[g]   = en_q;
    assign prio_o[g] = prio_q;

    AST_SET_ALIAS_ENABLES: assert property (@(posedge clk) disable iff (rst)
      hit && (sub == SUB_SET) && wdata_i[EN_BIT] |=> en_q) else $error("set alias"); // R3
    AST_CLR_ALIAS_DISABLES: assert property (@(posedge clk) disable iff (rst)
      hit && (sub == SUB_CLR) && wdata_i[EN_BIT] |=> !en_q) else $error("clear alias"); // R3
    AST_SET_KEEPS_PRIO: assert property (@(posedge clk) disable iff (rst)
      hit && (sub == SUB_SET) && (wdata_i[LVL_W-1:0] == '0) |=> $stable(prio_q)) else $error("set prio"); // R3
  end

  assign rd_hit_o = in_bank;

  always_comb begin
    rd_word_o = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (in_bank && (rel == SLOT_W'(i))) begin
        rd_word_o[EN_BIT]      = en_o[i];
        rd_word_o[LVL_W-1:0]   = prio_o[i];
      end
    end
  end
endmodule

// File: rtl/icol_arbiter.sv
module icol_arbiter #(
  parameter int NUM_SRC = 16,
  parameter int LVL_W   = 2,
  parameter int IDX_W   = 4
) (
  input  logic [NUM_SRC-1:0]            req_i,
  input  logic [NUM_SRC-1:0][LVL_W-1:0] prio_i,
  output logic                          found_o,
  output logic [IDX_W-1:0]              win_idx_o,
  output logic [LVL_W-1:0]              win_lvl_o
);
  // Walk from the highest index down; ">=" lets a lower index take over a tie.
  always_comb begin
    found_o   = 1'b0;
    win_idx_o = '0;
    win_lvl_o = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (req_i[i] && (!found_o || (prio_i[i] >= win_lvl_o))) begin
        found_o   = 1'b1;
        win_idx_o = IDX_W'(i);
        win_lvl_o = prio_i[i];
      end
    end
  end
endmodule

// File: rtl/icol_level_track.sv
module icol_level_track #(
  parameter int NUM_LVL = 4,
  parameter int LVL_W   = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               raise_i,
  input  logic [LVL_W-1:0]   raise_lvl_i,
  input  logic               ack_wr_i,
  input  logic [NUM_LVL-1:0] ack_data_i,
  output logic [NUM_LVL-1:0] in_svc_o,
  output logic               busy_o,
  output logic [LVL_W-1:0]   top_lvl_o
);
  logic [NUM_LVL-1:0] in_svc_q;
  logic               ack_onehot, ack_ok;
  logic [NUM_LVL-1:0] clr_mask, set_mask;

  assign ack_onehot = (ack_data_i != '0) &&
                      ((ack_data_i & (ack_data_i - NUM_LVL'(1))) == '0);
  assign ack_ok     = ack_wr_i && ack_onehot && ((ack_data_i & in_svc_q) != '0);
  assign clr_mask   = ack_ok ? ack_data_i : '0;
  assign set_mask   = raise_i ? (NUM_LVL'(1) << raise_lvl_i) : '0;

  always_ff @(posedge clk) begin
    if (rst) in_svc_q <= '0;
    else     in_svc_q <= (in_svc_q & ~clr_mask) | set_mask;
  end

  always_comb begin
    top_lvl_o = '0;
    for (int l = 0; l < NUM_LVL; l++) begin
      if (in_svc_q[l]) top_lvl_o = LVL_W'(l);
    end
  end

  assign busy_o   = |in_svc_q;
  assign in_svc_o = in_svc_q;

  AST_ACK_IGNORED: assert property (@(posedge clk) disable iff (rst)
    ack_wr_i && !ack_ok && !raise_i |=> in_svc_q == $past(in_svc_q)) else $error("bad ack changed mask"); // R9
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    ack_ok |=> (in_svc_q & $past(ack_data_i)) == '0) else $error("ack did not clear"); // R8
  AST_RAISE_MARKS: assert property (@(posedge clk) disable iff (rst)
    raise_i |=> in_svc_q[$past(raise_lvl_i)]) else $error("raise not marked"); // R6
endmodule

// File: rtl/prio_irq_collector.sv
module prio_irq_collector
  import icol_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int NUM_LVL = 4,
  parameter int ADDR_W  = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               irq_o
);
  localparam int LVL_W = (NUM_LVL > 1) ? $clog2(NUM_LVL) : 1;
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam logic [ADDR_W-1:0] ADDR_STAT = ADDR_W'('h000);
  localparam logic [ADDR_W-1:0] ADDR_VEC  = ADDR_W'('h010);
  localparam logic [ADDR_W-1:0] ADDR_ACK  = ADDR_W'('h020);

  logic [NUM_SRC-1:0]            en;
  logic [NUM_SRC-1:0][LVL_W-1:0] prio;
  logic [NUM_SRC-1:0]            req;
  logic                          bank_hit;
  logic [DATA_W-1:0]             bank_word;
  logic                          found;
  logic [IDX_W-1:0]              win_idx;
  logic [LVL_W-1:0]              win_lvl;
  logic [NUM_LVL-1:0]            in_svc;
  logic                          busy;
  logic [LVL_W-1:0]              top_lvl;
  logic                          eligible, raise, vec_wr, ack_wr;

  logic                          irq_q, live_q;
  logic [IDX_W-1:0]              sel_q;
  logic [LVL_W-1:0]              lvl_q;
  logic [DATA_W-1:0]             stat_word;
  logic [DATA_W-1:0]             rdata_q;

  icol_src_bank #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W), .ADDR_W(ADDR_W)) u_bank (
    .clk       (clk),
    .rst       (rst),
    .wr_i      (bus_wr),
    .addr_i    (bus_addr),
    .wdata_i   (bus_wdata),
    .en_o      (en),
    .prio_o    (prio),
    .rd_hit_o  (bank_hit),
    .rd_word_o (bank_word)
  );

  assign req = src_i & en;

  icol_arbiter #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W), .IDX_W(IDX_W)) u_arb (
    .req_i     (req),
    .prio_i    (prio),
    .found_o   (found),
    .win_idx_o (win_idx),
    .win_lvl_o (win_lvl)
  );

  assign eligible = found && (!busy || (win_lvl > top_lvl));
  assign raise    = !irq_q && eligible;
  assign vec_wr   = bus_wr && (bus_addr == ADDR_VEC);
  assign ack_wr   = bus_wr && (bus_addr == ADDR_ACK);

  icol_level_track #(.NUM_LVL(NUM_LVL), .LVL_W(LVL_W)) u_lvl (
    .clk         (clk),
    .rst         (rst),
    .raise_i     (raise),
    .raise_lvl_i (win_lvl),
    .ack_wr_i    (ack_wr),
    .ack_data_i  (bus_wdata[NUM_LVL-1:0]),
    .in_svc_o    (in_svc),
    .busy_o      (busy),
    .top_lvl_o   (top_lvl)
  );

  // Presentation state: request flag, latched source, its level, and whether it is still live.
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q  <= 1'b0;
      live_q <= 1'b0;
      sel_q  <= '0;
      lvl_q  <= '0;
    end else if (irq_q) begin
      if (vec_wr) begin
        irq_q  <= 1'b0;
        live_q <= 1'b0;
        lvl_q  <= '0;
      end else if (!req[sel_q]) begin
        live_q <= 1'b0;
      end
    end else if (raise) begin
      irq_q  <= 1'b1;
      live_q <= 1'b1;
      sel_q  <= win_idx;
      lvl_q  <= win_lvl;
    end
  end

  always_comb begin
    stat_word = '0;
    stat_word[VEC_W-1:0] = (irq_q && live_q) ? VEC_W'(sel_q) : NO_SRC;
    if (irq_q) stat_word[LVL_POS +: LVL_W] = lvl_q;
    stat_word[DATA_W-1] = irq_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (bus_rd) begin
      if (bus_addr == ADDR_STAT)     rdata_q <= stat_word;
      else if (bus_addr == ADDR_ACK) rdata_q <= DATA_W'(in_svc);
      else if (bank_hit)             rdata_q <= bank_word;
      else                           rdata_q <= '0;
    end
  end

  assign bus_rdata = rdata_q;
  assign irq_o     = irq_q;

  AST_VECWR_DROPS: assert property (@(posedge clk) disable iff (rst)
    vec_wr |=> !irq_q) else $error("vector write kept request"); // R7
  AST_RAISE_ABOVE_SVC: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_q) |-> (($past(in_svc) == '0) || (lvl_q > $past(top_lvl)))) else $error("raise not above service"); // R6
  AST_RAISE_FROM_WINNER: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_q) |-> $past(found) && live_q) else $error("raise without pending source"); // R4
  AST_HOLD_UNTIL_VECWR: assert property (@(posedge clk) disable iff (rst)
    irq_q && !vec_wr |=> irq_q && $stable(lvl_q) && $stable(sel_q)) else $error("request changed while presented"); // R10
endmodule

// File: tb/sim_prio_irq_collector.sv
module sim_prio_irq_collector;
  localparam int NUM_SRC = 16;
  localparam int ADDR_W  = 12;
  localparam logic [ADDR_W-1:0] A_STAT = 12'h000;
  localparam logic [ADDR_W-1:0] A_VEC  = 12'h010;
  localparam logic [ADDR_W-1:0] A_ACK  = 12'h020;

  // {source lines, expected vector (7f = none), expected level}
  // Config: priority of source n is n%4, all enabled except sources 3 and 6.
  localparam int NVEC = 8;
  localparam logic [24:0] TBL [NVEC] = '{
    {16'h0001, 7'd0,   2'd0},
    {16'h0006, 7'd2,   2'd2},
    {16'h0088, 7'd7,   2'd3},
    {16'h0048, 7'h7f,  2'd0},
    {16'h0220, 7'd5,   2'd1},
    {16'h8410, 7'd15,  2'd3},
    {16'h0C00, 7'd11,  2'd3},
    {16'h0440, 7'd10,  2'd2}
  };

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic [NUM_SRC-1:0] src_i = '0;
  logic               bus_wr = 1'b0;
  logic               bus_rd = 1'b0;
  logic [ADDR_W-1:0]  bus_addr = '0;
  logic [31:0]        bus_wdata = '0;
  logic [31:0]        bus_rdata;
  logic               irq_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  prio_irq_collector #(.NUM_SRC(NUM_SRC), .NUM_LVL(4), .ADDR_W(ADDR_W)) u0 (
    .clk(clk), .rst(rst), .src_i(src_i), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic set_src(input logic [NUM_SRC-1:0] v);
    @(negedge clk);
    src_i = v;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  function automatic logic [31:0] stat_val(input bit irq, input logic [1:0] lvl, input logic [6:0] vec);
    return {irq, 21'd0, lvl, 1'b0, vec};
  endfunction

  initial begin
    logic [31:0] rd;
    logic [15:0] pat;
    logic [6:0]  evec;
    logic [1:0]  elvl;
    idle(3);
    rst = 1'b0;
    @(negedge clk);

    // Reset state
    check_eq("R1 irq after reset", 32'(irq_o), 32'd0);
    bus_read(A_STAT, rd); check_eq("R1 status after reset", rd, 32'h0000007f);
    bus_read(12'h100, rd); check_eq("R1 control word 0 after reset", rd, 32'd0);
    bus_read(A_ACK, rd);   check_eq("R1 in-service after reset", rd, 32'd0);

    // Configuration through direct writes
    for (int n = 0; n < NUM_SRC; n++) begin
      bus_write(12'h100 + 12'(n * 16), {27'd0, (n != 3 && n != 6), 2'b00, 2'(n % 4)});
    end
    bus_read(12'h120, rd); check_eq("R2 control word 2", rd, 32'h00000012);
    bus_read(12'h130, rd); check_eq("R2 control word 3 disabled", rd, 32'h00000003);

    // Table of arbitration cases
    for (int t = 0; t < NVEC; t++) begin
      pat  = TBL[t][24:9];
      evec = TBL[t][8:2];
      elvl = TBL[t][1:0];
      set_src(pat);
      if (evec == 7'h7f) begin
        check_eq($sformatf("R4 case %0d no winner irq", t), 32'(irq_o), 32'd0);
        bus_read(A_STAT, rd); check_eq($sformatf("R4 case %0d status", t), rd, 32'h0000007f);
        src_i = '0;
      end else begin
        check_eq($sformatf("R5 case %0d irq raised", t), 32'(irq_o), 32'd1);
        bus_read(A_STAT, rd);
        check_eq($sformatf("R4 case %0d status", t), rd, stat_val(1'b1, elvl, evec));
        bus_write(A_VEC, 32'hffffffff);
        src_i = '0;
        check_eq($sformatf("R7 case %0d irq dropped", t), 32'(irq_o), 32'd0);
        bus_write(A_ACK, 32'(4'b0001 << elvl));
        bus_read(A_ACK, rd); check_eq($sformatf("R8 case %0d level freed", t), rd, 32'd0);
      end
    end

    // Nesting: equal and lower levels are held back, higher levels get through
    set_src(16'h0002);
    check_eq("R5 src1 raised", 32'(irq_o), 32'd1);
    bus_write(A_VEC, 32'd0);
    bus_read(A_STAT, rd); check_eq("R7 status after vector write", rd, 32'h0000007f);
    idle(2);
    check_eq("R6 equal level blocked", 32'(irq_o), 32'd0);
    set_src(16'h0003);
    idle(2);
    check_eq("R6 lower level blocked", 32'(irq_o), 32'd0);
    set_src(16'h0007);
    check_eq("R6 higher level nests", 32'(irq_o), 32'd1);
    bus_read(A_STAT, rd); check_eq("R6 nested status", rd, stat_val(1'b1, 2'd2, 7'd2));
    bus_read(A_ACK, rd);  check_eq("R8 two levels in service", rd, 32'h00000006);
    bus_write(A_VEC, 32'd0);
    src_i = 16'h0003;
    bus_write(A_ACK, 32'h4);
    bus_read(A_ACK, rd);  check_eq("R8 level 2 acknowledged", rd, 32'h00000002);
    check_eq("R6 still blocked by level 1", 32'(irq_o), 32'd0);
    bus_write(A_ACK, 32'h3);
    idle(2);
    bus_read(A_ACK, rd);  check_eq("R9 non one-hot ignored", rd, 32'h00000002);
    check_eq("R9 no raise after bad ack", 32'(irq_o), 32'd0);
    bus_write(A_ACK, 32'h8);
    idle(2);
    bus_read(A_ACK, rd);  check_eq("R9 level not in service ignored", rd, 32'h00000002);
    bus_write(A_ACK, 32'h2);
    @(negedge clk);
    check_eq("R6 re-raise after ack", 32'(irq_o), 32'd1);
    bus_read(A_STAT, rd); check_eq("R4 re-raise picks level 1", rd, stat_val(1'b1, 2'd1, 7'd1));
    src_i = '0;
    bus_write(A_VEC, 32'd0);
    bus_write(A_ACK, 32'h2);

    // Spurious: line falls before the handler reads
    set_src(16'h0010);
    check_eq("R5 src4 raised", 32'(irq_o), 32'd1);
    set_src(16'h0000);
    bus_read(A_STAT, rd); check_eq("R10 line dropped reads spurious", rd, stat_val(1'b1, 2'd0, 7'h7f));
    bus_read(A_ACK, rd);  check_eq("R10 level kept in service", rd, 32'h00000001);
    bus_write(A_VEC, 32'd0);
    bus_write(A_ACK, 32'h1);
    bus_read(A_ACK, rd);  check_eq("R8 spurious level acknowledged", rd, 32'd0);

    // Spurious: source disabled through the clear alias
    set_src(16'h0020);
    check_eq("R5 src5 raised", 32'(irq_o), 32'd1);
    bus_write(12'h158, 32'h10);
    bus_read(A_STAT, rd); check_eq("R10 disabled reads spurious", rd, stat_val(1'b1, 2'd1, 7'h7f));
    bus_read(12'h150, rd); check_eq("R3 clear alias kept priority", rd, 32'h00000001);
    src_i = '0;
    bus_write(A_VEC, 32'd0);
    bus_write(A_ACK, 32'h2);
    bus_write(12'h154, 32'h10);
    bus_read(12'h150, rd); check_eq("R3 set alias re-enabled", rd, 32'h00000011);

    // Aliases on a disabled source
    bus_write(12'h134, 32'h10);
    bus_read(12'h130, rd); check_eq("R3 set alias enable only", rd, 32'h00000013);
    bus_write(12'h138, 32'h1);
    bus_read(12'h130, rd); check_eq("R3 clear alias priority bit", rd, 32'h00000012);

    // Direct write replaces the word, other bits not stored
    bus_write(12'h190, 32'hffffffef);
    bus_read(12'h190, rd); check_eq("R2 direct write replaces", rd, 32'h00000003);

    // Unmapped reads
    bus_read(12'h040, rd); check_eq("R11 unmapped read", rd, 32'd0);
    bus_read(12'h200, rd); check_eq("R11 slot beyond last source", rd, 32'd0);
    bus_read(A_VEC, rd);   check_eq("R11 vector register reads zero", rd, 32'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int c = 0; c < 200000; c++) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R11 actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule